// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block chooses the address of the next micro-instruction in a vertically encoded microprogrammed control unit. Each cycle it reads the sequencing fields of the micro-instruction now being executed: a 4-bit sequencing code, a 4-bit flag-value field and a branch target. It also samples the CPU condition flags and the type and function fields of the machine instruction being executed. From these it loads the control-store address register, which addresses the control store for the following cycle.

Inside it are the address register with its incrementer, a small last-in-first-out stack of return addresses for micro-subroutines, and a loop counter whose zero state can be tested like any other flag. A three-way address multiplexer picks the incremented (or, for a repeat, non-incremented) address, the branch target or the top of the stack. Conditional branches compare a selected group of flags with the flag-value field. When a group is narrower than the field, its spare high positions are read as 1.

Top module: `useq_next_addr`

## Requirements
- R1: After reset the address register is 0, both stack error outputs are low, the return stack is empty and the loop counter is 0, so its zero flag reads 1.
- R2: Code 0000 loads the address register with its current value plus one, wrapping from all ones to 0. The unused codes 0100, 0111, 1010, 1011, 1110 and 1111 behave the same way and touch neither the stack nor the loop counter.
- R3: Code 0001 loads the branch target. Code 0010 leaves the address register unchanged.
- R4: Code 1000 compares the flag-value field with {1, type[2:0]}. On equality it loads the branch target, otherwise the current address plus one.
- R5: Code 1001 compares the flag-value field with func[3:0]. On equality it loads the branch target, otherwise the current address plus one.
- R6: Code 1100 compares the flag-value field with {Z, S, C, O}, Z in bit 3 and O in bit 0. On equality it loads the branch target, otherwise the current address plus one.
- R7: Code 1101 compares the flag-value field with {1, 1, 1, LZ}, where LZ is 1 exactly when the loop counter is 0. On equality it loads the branch target. A taken branch with a nonzero counter decrements the counter by one.
- R8: Code 0011 loads the loop counter from the low 4 bits of the branch target and steps the address by one.
- R9: Code 0101 pushes the current address plus one and loads the branch target. Code 0110 pops the stack and loads the popped address, in last-in-first-out order.
- R10: Code 0101 with four entries already stacked raises stk_ovf in that cycle, holds the address register and leaves the stack contents unchanged.
- R11: Code 0110 with an empty stack raises stk_unf in that cycle and holds the address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seq_code | input | 4 | Sequencing code of the current micro-instruction |
| fval | input | 4 | Flag-value field for conditional branches |
| br_addr | input | 8 | Branch target; low 4 bits also load the loop counter |
| flag_z | input | 1 | CPU zero flag |
| flag_s | input | 1 | CPU sign flag |
| flag_c | input | 1 | CPU carry flag |
| flag_o | input | 1 | CPU overflow flag |
| itype | input | 3 | Type field of the machine instruction |
| ifunc | input | 4 | Function field of the machine instruction |
| csar | output | 8 | Control-store address register |
| stk_ovf | output | 1 | Call attempted with the stack full (current cycle) |
| stk_unf | output | 1 | Return attempted with the stack empty (current cycle) |

## Verification
Two functions share a cycle when a subroutine call meets a full stack: the push request and the overflow hold both fire in the cycle of the call. The bench fills the stack with four nested calls, issues a fifth, and checks that stk_ovf is high before the edge and that the address register holds after it. It then unwinds with returns and expects exactly the four stored addresses in reverse order, which shows that the refused push left the stack unchanged. The same pairing happens in a taken loop-back branch, which redirects the address and decrements the counter in one cycle. There the bench counts how many times the branch is taken before it falls through.

// File: rtl/useq_pkg.sv
package useq_pkg;

   // Sequencing codes carried by the micro-instruction
   localparam logic [3:0] SQ_INLINE  = 4'b0000;
   localparam logic [3:0] SQ_JUMP    = 4'b0001;
   localparam logic [3:0] SQ_REPEAT  = 4'b0010;
   localparam logic [3:0] SQ_LOOP    = 4'b0011;
   localparam logic [3:0] SQ_CALL    = 4'b0101;
   localparam logic [3:0] SQ_RET     = 4'b0110;
   localparam logic [3:0] SQ_BR_TYPE = 4'b1000;
   localparam logic [3:0] SQ_BR_FUNC = 4'b1001;
   localparam logic [3:0] SQ_BR_CPU  = 4'b1100;
   localparam logic [3:0] SQ_BR_LZ   = 4'b1101;

   // Address multiplexer selects
   typedef enum logic [1:0] {
      AM_NONE   = 2'b00,
      AM_INC    = 2'b01,
      AM_BRANCH = 2'b10,
      AM_STACK  = 2'b11
   } amux_e;

   typedef struct packed {
      amux_e sel;
      logic  inc_en;
      logic  push;
      logic  pop;
      logic  load_lc;
      logic  dec_lc;
   } seq_ctl_t;

endpackage

// File: rtl/useq_cond_eval.sv
module useq_cond_eval
   import useq_pkg::*;
#(
   parameter int FVAL_W = 4,
   parameter int TYPE_W = 3,
   parameter int FUNC_W = 4
) (
   input  logic [3:0]        seq_code,
   input  logic [FVAL_W-1:0] fval,
   input  logic              flag_z,
   input  logic              flag_s,
   input  logic              flag_c,
   input  logic              flag_o,
   input  logic [TYPE_W-1:0] itype,
   input  logic [FUNC_W-1:0] ifunc,
   input  logic              lz,
   output logic              taken
);

   localparam int TPAD = FVAL_W - TYPE_W;
   localparam int FPAD = FVAL_W - FUNC_W;
   localparam int CPAD = FVAL_W - 4;
   localparam int LPAD = FVAL_W - 1;

   logic [FVAL_W-1:0] type_grp;
   logic [FVAL_W-1:0] func_grp;
   logic [FVAL_W-1:0] cpu_grp;
   logic [FVAL_W-1:0] lz_grp;
   logic [FVAL_W-1:0] sel_grp;
   logic              is_cond;

   initial begin
      assert (TYPE_W >= 1 && TYPE_W <= FVAL_W) else $error("TYPE_W out of range");
      assert (FUNC_W >= 1 && FUNC_W <= FVAL_W) else $error("FUNC_W out of range");
      assert (FVAL_W >= 4) else $error("FVAL_W must hold four CPU flags");
   end

   // Narrow groups get their spare high positions driven to 1
   generate
      if (TPAD > 0) begin : g_type_pad
         assign type_grp = {{TPAD{1'b1}}, itype};
      end else begin : g_type_full
         assign type_grp = itype;
      end
      if (FPAD > 0) begin : g_func_pad
         assign func_grp = {{FPAD{1'b1}}, ifunc};
      end else begin : g_func_full
         assign func_grp = ifunc;
      end
      if (CPAD > 0) begin : g_cpu_pad
         assign cpu_grp = {{CPAD{1'b1}}, flag_z, flag_s, flag_c, flag_o};
      end else begin : g_cpu_full
         assign cpu_grp = {flag_z, flag_s, flag_c, flag_o};
      end
   endgenerate

   assign lz_grp = {{LPAD{1'b1}}, lz};

   always_comb begin
      sel_grp = '0;
      is_cond = 1'b1;
      case (seq_code)
         SQ_BR_TYPE: sel_grp = type_grp;
         SQ_BR_FUNC: sel_grp = func_grp;
         SQ_BR_CPU:  sel_grp = cpu_grp;
         SQ_BR_LZ:   sel_grp = lz_grp;
         default:    is_cond = 1'b0;
      endcase
   end

   assign taken = is_cond && (sel_grp == fval);

endmodule

// File: rtl/useq_decode.sv
module useq_decode
   import useq_pkg::*;
(
   input  logic     [3:0] seq_code,
   input  logic           taken,
   input  logic           stk_full,
   input  logic           stk_empty,
   input  logic           lz,
   output seq_ctl_t       ctl,
   output logic           ovf,
   output logic           unf
);

   always_comb begin
      ctl.sel     = AM_INC;
      ctl.inc_en  = 1'b1;
      ctl.push    = 1'b0;
      ctl.pop     = 1'b0;
      ctl.load_lc = 1'b0;
      ctl.dec_lc  = 1'b0;
      ovf         = 1'b0;
      unf         = 1'b0;
      case (seq_code)
         SQ_JUMP:   ctl.sel = AM_BRANCH;
         SQ_REPEAT: ctl.inc_en = 1'b0;
         SQ_LOOP:   ctl.load_lc = 1'b1;
         SQ_CALL: begin
            if (stk_full) begin
               ctl.inc_en = 1'b0;
               ovf        = 1'b1;
            end else begin
               ctl.sel  = AM_BRANCH;
               ctl.push = 1'b1;
            end
         end
         SQ_RET: begin
            if (stk_empty) begin
               ctl.inc_en = 1'b0;
               unf        = 1'b1;
            end else begin
               ctl.sel = AM_STACK;
               ctl.pop = 1'b1;
            end
         end
         SQ_BR_TYPE, SQ_BR_FUNC, SQ_BR_CPU: begin
            if (taken) ctl.sel = AM_BRANCH;
         end
         SQ_BR_LZ: begin
            if (taken) begin
               ctl.sel    = AM_BRANCH;
               ctl.dec_lc = !lz;
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/useq_ret_stack.sv
module useq_ret_stack #(
   parameter int AW    = 8,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [AW-1:0] push_data,
   output logic [AW-1:0] top,
   output logic          full,
   output logic          empty
);

   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] cnt;
   logic [AW-1:0] mem [DEPTH];

   initial begin
      assert (DEPTH >= 1 && DEPTH <= 64) else $error("DEPTH out of range");
   end

   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (push && !full) begin
         cnt <= cnt + CW'(1);
      end else if (pop && !empty) begin
         cnt <= cnt - CW'(1);
      end
   end

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem[i] <= '0;
            end else if (push && !full && (cnt == CW'(i))) begin
               mem[i] <= push_data;
            end
         end
      end
   endgenerate

   always_comb begin
      top = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (cnt == CW'(i + 1)) top = mem[i];
      end
   end

   AST_FULL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);                                                    // R10
   AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (cnt == $past(cnt) + CW'(1)));                             // R9
   AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |=> (cnt == $past(cnt) - CW'(1)));                   // R9
   AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !pop);                                                    // R11

endmodule

// File: rtl/useq_loop_ctr.sv
module useq_loop_ctr #(
   parameter int LOOP_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LOOP_W-1:0] load_val,
   input  logic              dec,
   output logic              lz
);

   logic [LOOP_W-1:0] cnt;

   initial begin
      assert (LOOP_W >= 1) else $error("LOOP_W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (dec && (cnt != '0)) begin
         cnt <= cnt - LOOP_W'(1);
      end
   end

   assign lz = (cnt == '0);

   AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (lz == ($past(load_val) == '0)));                          // R8
   AST_DEC_ONLY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> !lz);                                                       // R7
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !dec) |=> $stable(lz));                                   // R2

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
   import useq_pkg::*;
#(
   parameter int AW        = 8,
   parameter int FVAL_W    = 4,
   parameter int TYPE_W    = 3,
   parameter int FUNC_W    = 4,
   parameter int STK_DEPTH = 4,
   parameter int LOOP_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        seq_code,
   input  logic [FVAL_W-1:0] fval,
   input  logic [AW-1:0]     br_addr,
   input  logic              flag_z,
   input  logic              flag_s,
   input  logic              flag_c,
   input  logic              flag_o,
   input  logic [TYPE_W-1:0] itype,
   input  logic [FUNC_W-1:0] ifunc,
   output logic [AW-1:0]     csar,
   output logic              stk_ovf,
   output logic              stk_unf
);

   seq_ctl_t      ctl;
   logic          taken;
   logic          lz;
   logic          stk_full;
   logic          stk_empty;
   logic [AW-1:0] stk_top;
   logic [AW-1:0] upc;
   logic [AW-1:0] next_addr;

   initial begin
      assert (LOOP_W <= AW) else $error("LOOP_W exceeds AW");
      assert (AW >= 2) else $error("AW too small");
   end

   useq_cond_eval #(
      .FVAL_W (FVAL_W),
      .TYPE_W (TYPE_W),
      .FUNC_W (FUNC_W)
   ) u_cond (
      .seq_code (seq_code),
      .fval     (fval),
      .flag_z   (flag_z),
      .flag_s   (flag_s),
      .flag_c   (flag_c),
      .flag_o   (flag_o),
      .itype    (itype),
      .ifunc    (ifunc),
      .lz       (lz),
      .taken    (taken)
   );

   useq_decode u_dec (
      .seq_code  (seq_code),
      .taken     (taken),
      .stk_full  (stk_full),
      .stk_empty (stk_empty),
      .lz        (lz),
      .ctl       (ctl),
      .ovf       (stk_ovf),
      .unf       (stk_unf)
   );

   // Incremented micro-PC; a repeat suppresses the increment
   assign upc = ctl.inc_en ? (csar + AW'(1)) : csar;

   useq_ret_stack #(
      .AW    (AW),
      .DEPTH (STK_DEPTH)
   ) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (ctl.push),
      .pop       (ctl.pop),
      .push_data (csar + AW'(1)),
      .top       (stk_top),
      .full      (stk_full),
      .empty     (stk_empty)
   );

   useq_loop_ctr #(
      .LOOP_W (LOOP_W)
   ) u_loop (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ctl.load_lc),
      .load_val (br_addr[LOOP_W-1:0]),
      .dec      (ctl.dec_lc),
      .lz       (lz)
   );

   always_comb begin
      case (ctl.sel)
         AM_INC:    next_addr = upc;
         AM_BRANCH: next_addr = br_addr;
         AM_STACK:  next_addr = stk_top;
         default:   next_addr = csar;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) csar <= '0;
      else        csar <= next_addr;
   end

   AST_INLINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_code == SQ_INLINE) |=> (csar == $past(csar) + AW'(1)));        // R2
   AST_REPEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_code == SQ_REPEAT) |=> $stable(csar));                         // R3
   AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_code == SQ_JUMP) |=> (csar == $past(br_addr)));                // R3
   AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_code == SQ_RET && !stk_empty) |=> (csar == $past(stk_top)));   // R9
   AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      stk_ovf |=> $stable(csar));                                         // R10
   AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      stk_unf |=> $stable(csar));                                         // R11
   AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stk_ovf, stk_unf}));                                      // R10

endmodule

// File: tb/tb_useq_next_addr.sv
`timescale 1ns/1ps
module tb_useq_next_addr;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] seq_code;
   logic [3:0] fval;
   logic [7:0] br_addr;
   logic       flag_z, flag_s, flag_c, flag_o;
   logic [2:0] itype;
   logic [3:0] ifunc;
   logic [7:0] csar;
   logic       stk_ovf, stk_unf;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   useq_next_addr dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .seq_code (seq_code),
      .fval     (fval),
      .br_addr  (br_addr),
      .flag_z   (flag_z),
      .flag_s   (flag_s),
      .flag_c   (flag_c),
      .flag_o   (flag_o),
      .itype    (itype),
      .ifunc    (ifunc),
      .csar     (csar),
      .stk_ovf  (stk_ovf),
      .stk_unf  (stk_unf)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // One micro-instruction: apply at negedge, check flags before the edge, address after it
   task automatic step(input string req, input logic [3:0] code, input logic [3:0] fv,
                       input logic [7:0] ba, input logic [7:0] exp_addr,
                       input logic exp_ovf, input logic exp_unf);
      @(negedge clk);
      seq_code = code;
      fval     = fv;
      br_addr  = ba;
      #2;
      check({req, " ovf"}, {7'd0, stk_ovf}, {7'd0, exp_ovf});
      check({req, " unf"}, {7'd0, stk_unf}, {7'd0, exp_unf});
      @(posedge clk);
      #1;
      check({req, " addr"}, csar, exp_addr);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; seq_code = 4'b0000; fval = 4'h0; br_addr = 8'h00;
      flag_z = 1'b0; flag_s = 1'b0; flag_c = 1'b0; flag_o = 1'b0;
      itype = 3'd0; ifunc = 4'd0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset addr", csar, 8'h00);
      check("R1 reset ovf", {7'd0, stk_ovf}, 8'h00);
      check("R1 reset unf", {7'd0, stk_unf}, 8'h00);
      rst_n = 1'b1;
      step("R1 R7 counter zero after reset", 4'b1101, 4'b1111, 8'h33, 8'h33, 1'b0, 1'b0);
      step("R1 R11 stack empty after reset", 4'b0110, 4'h0, 8'h00, 8'h33, 1'b0, 1'b1);
   endtask

   task automatic t_inline_jump();
      step("R2 inline", 4'b0000, 4'h0, 8'h00, 8'h34, 1'b0, 1'b0);
      step("R2 inline", 4'b0000, 4'h0, 8'h00, 8'h35, 1'b0, 1'b0);
      step("R3 jump", 4'b0001, 4'h0, 8'h40, 8'h40, 1'b0, 1'b0);
      step("R3 repeat", 4'b0010, 4'h0, 8'h99, 8'h40, 1'b0, 1'b0);
      step("R3 repeat", 4'b0010, 4'h0, 8'h99, 8'h40, 1'b0, 1'b0);
      step("R2 inline after repeat", 4'b0000, 4'h0, 8'h99, 8'h41, 1'b0, 1'b0);
      step("R3 jump to top", 4'b0001, 4'h0, 8'hFF, 8'hFF, 1'b0, 1'b0);
      step("R2 wrap", 4'b0000, 4'h0, 8'h00, 8'h00, 1'b0, 1'b0);
   endtask

   task automatic t_unused();
      step("R2 unused 0100", 4'b0100, 4'hF, 8'hE0, 8'h01, 1'b0, 1'b0);
      step("R2 unused 0111", 4'b0111, 4'hF, 8'hE0, 8'h02, 1'b0, 1'b0);
      step("R2 unused 1010", 4'b1010, 4'hF, 8'hE0, 8'h03, 1'b0, 1'b0);
      step("R2 unused 1011", 4'b1011, 4'hF, 8'hE0, 8'h04, 1'b0, 1'b0);
      step("R2 unused 1110", 4'b1110, 4'hF, 8'hE0, 8'h05, 1'b0, 1'b0);
      step("R2 unused 1111", 4'b1111, 4'hF, 8'hE0, 8'h06, 1'b0, 1'b0);
   endtask

   task automatic t_cond();
      itype = 3'd5;
      step("R4 type match", 4'b1000, 4'b1101, 8'h80, 8'h80, 1'b0, 1'b0);
      step("R4 type pad must be 1", 4'b1000, 4'b0101, 8'h90, 8'h81, 1'b0, 1'b0);
      itype = 3'd2;
      step("R4 type match 2", 4'b1000, 4'b1010, 8'h90, 8'h90, 1'b0, 1'b0);
      ifunc = 4'd9;
      step("R5 func match", 4'b1001, 4'b1001, 8'hA0, 8'hA0, 1'b0, 1'b0);
      step("R5 func miss", 4'b1001, 4'b1000, 8'hB0, 8'hA1, 1'b0, 1'b0);
      flag_z = 1'b1; flag_s = 1'b0; flag_c = 1'b1; flag_o = 1'b0;
      step("R6 cpu match", 4'b1100, 4'b1010, 8'hC0, 8'hC0, 1'b0, 1'b0);
      step("R6 cpu reversed", 4'b1100, 4'b0101, 8'hD0, 8'hC1, 1'b0, 1'b0);
      step("R6 cpu one bit off", 4'b1100, 4'b1011, 8'hD0, 8'hC2, 1'b0, 1'b0);
   endtask

   task automatic t_loop();
      step("R3 jump", 4'b0001, 4'h0, 8'h10, 8'h10, 1'b0, 1'b0);
      step("R8 loop start", 4'b0011, 4'h0, 8'h03, 8'h11, 1'b0, 1'b0);
      for (int k = 0; k < 3; k++)
         step("R7 loop back taken", 4'b1101, 4'b1110, 8'h11, 8'h11, 1'b0, 1'b0);
      step("R7 loop exit", 4'b1101, 4'b1110, 8'h11, 8'h12, 1'b0, 1'b0);
      step("R7 zero flag taken", 4'b1101, 4'b1111, 8'h90, 8'h90, 1'b0, 1'b0);
      step("R8 load low bits zero", 4'b0011, 4'h0, 8'hF0, 8'h91, 1'b0, 1'b0);
      step("R8 loaded zero seen", 4'b1101, 4'b1111, 8'h20, 8'h20, 1'b0, 1'b0);
   endtask

   task automatic t_call_ret();
      step("R9 call", 4'b0101, 4'h0, 8'h30, 8'h30, 1'b0, 1'b0);
      step("R9 nested call", 4'b0101, 4'h0, 8'h50, 8'h50, 1'b0, 1'b0);
      step("R2 unused keeps stack", 4'b0100, 4'h0, 8'h00, 8'h51, 1'b0, 1'b0);
      step("R9 return inner", 4'b0110, 4'h0, 8'h00, 8'h31, 1'b0, 1'b0);
      step("R9 return outer", 4'b0110, 4'h0, 8'h00, 8'h21, 1'b0, 1'b0);
      step("R11 underflow", 4'b0110, 4'h0, 8'h00, 8'h21, 1'b0, 1'b1);
   endtask

   task automatic t_overflow();
      step("R3 jump", 4'b0001, 4'h0, 8'h60, 8'h60, 1'b0, 1'b0);
      step("R9 fill 1", 4'b0101, 4'h0, 8'h70, 8'h70, 1'b0, 1'b0);
      step("R9 fill 2", 4'b0101, 4'h0, 8'h71, 8'h71, 1'b0, 1'b0);
      step("R9 fill 3", 4'b0101, 4'h0, 8'h72, 8'h72, 1'b0, 1'b0);
      step("R9 fill 4", 4'b0101, 4'h0, 8'h73, 8'h73, 1'b0, 1'b0);
      step("R10 overflow", 4'b0101, 4'h0, 8'h7F, 8'h73, 1'b1, 1'b0);
      step("R10 pop 4", 4'b0110, 4'h0, 8'h00, 8'h73, 1'b0, 1'b0);
      step("R10 pop 3", 4'b0110, 4'h0, 8'h00, 8'h72, 1'b0, 1'b0);
      step("R10 pop 2", 4'b0110, 4'h0, 8'h00, 8'h71, 1'b0, 1'b0);
      step("R10 pop 1", 4'b0110, 4'h0, 8'h00, 8'h61, 1'b0, 1'b0);
      step("R11 underflow after drain", 4'b0110, 4'h0, 8'h00, 8'h61, 1'b0, 1'b1);
   endtask

   initial begin
      t_reset();
      t_inline_jump();
      t_unused();
      t_cond();
      t_loop();
      t_call_ret();
      t_overflow();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule